// File: doc/BRIEF.md
# Decode Stage Skid Buffer Controller

This block controls the flow of one thread through a pipeline stage that sits between an instruction source (upstream) and an instruction consumer (downstream). Every cycle it accepts a bundle of up to `IN_W` opaque tagged entries. It forwards up to `OUT_W` of them, oldest first. Entries that cannot leave are parked in a skid buffer of `LAT*IN_W + OUT_W` entries, where `LAT` is the upstream-to-stage latency in cycles. This size covers the entries still in flight after the stage tells its source to stop.

The controller runs a five-state status machine: Idle, Running, Blocked, Unblocking and Squashing. Three downstream sources can each stall the stage with block and unblock pulses. A squash request and a "squash still in progress" level flush the stage. The controller answers its source with single-cycle block and unblock pulses. While it recovers from a stall, it empties the skid buffer before any newly arriving entry is forwarded. All outputs are registered, so the result of a cycle's inputs is visible during the following cycle.

Top module: `dec_skid_ctrl`

## Requirements
- R1: After reset, `state_o` is Idle (0). `out_cnt_o`, `up_block_o`, `up_unblock_o` and `skid_ovf_o` are 0, and all three stall flags are clear. The state encoding is Idle=0, Running=1, Blocked=2, Unblocking=3, Squashing=4.
- R2: Each downstream source k owns a stall flag. `stall_set_i[k]` sets the flag and `stall_clr_i[k]` clears it; when both are high in the same cycle, the clear wins. The stage is stalled whenever any flag is set after that cycle's update. A stalled cycle forwards nothing and parks the whole input bundle in the skid buffer.
- R3: Each cycle is resolved in this priority order: squash request, then the busy level, then a stall, then recovery from Blocked, then normal forwarding. Squashing with no request and no busy level returns to Running and forwards that cycle's input.
- R4: `up_block_o` pulses only in the cycle after the state enters Blocked from any other state. It never pulses while the state stays Blocked, and it is never high together with `up_unblock_o`.
- R5: At most `OUT_W` entries leave per cycle, in slot order. Slot k of `in_tag_i` and `out_tag_o` is bits `[k*TAG_W +: TAG_W]`, and slot 0 is the oldest. If input entries remain after the width is used, the rest go to the skid buffer and the state becomes Blocked.
- R6: In Unblocking, and in Blocked once no stall remains while the skid buffer holds entries, entries leave from the skid buffer head. That cycle's whole input is appended behind the remaining skid entries.
- R7: Recovery ends in the cycle the skid buffer becomes empty: `up_unblock_o` pulses and the state is Running. Leaving Blocked with an empty skid buffer goes straight to Running with an unblock pulse and forwards that cycle's input.
- R8: An entry whose `in_kill_i` bit is 1 is discarded and does not use an output slot.
- R9: A squash request empties the skid buffer, discards the input and enters Squashing. `up_unblock_o` pulses if the prior state was Blocked or Unblocking.
- R10: While the busy level is high and no squash request is present, the state stays Squashing. Input and skid contents are discarded, and an unblock pulse is sent if the prior state was Blocked or Unblocking.
- R11: If the skid buffer would exceed `LAT*IN_W + OUT_W` entries, the newest excess entries are dropped and `skid_ovf_o` pulses for one cycle.
- R12: Idle stays Idle on cycles with an empty input bundle. The first cycle that forwards without blocking moves the state to Running.
- R13: Outputs are registered: the outputs for inputs presented before a clock edge appear after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_cnt_i | input | $clog2(IN_W+1) | Number of valid input slots, filled from slot 0 |
| in_tag_i | input | IN_W*TAG_W | Input entry tags, slot 0 in the low bits |
| in_kill_i | input | IN_W | Per-slot squashed mark |
| stall_set_i | input | 3 | Block pulses, one per downstream source |
| stall_clr_i | input | 3 | Unblock pulses, one per downstream source |
| squash_i | input | 1 | Squash request |
| sq_busy_i | input | 1 | Squash still in progress |
| out_cnt_o | output | $clog2(OUT_W+1) | Number of forwarded entries |
| out_tag_o | output | OUT_W*TAG_W | Forwarded tags, slot 0 oldest |
| up_block_o | output | 1 | Block pulse to the source |
| up_unblock_o | output | 1 | Unblock pulse to the source |
| state_o | output | 3 | Current status |
| skid_ovf_o | output | 1 | Skid buffer overflow pulse |

## Verification
The cases that matter most are those where two functions fall on the same edge. A squash request can arrive in the same cycle as a stall pulse. The busy level can coincide with a set stall flag. A stall can clear in the same cycle as recovery, so the skid buffer drains while new input is appended behind it. A Blocked stage with an empty skid buffer can unblock and forward in a single cycle. The directed scenarios provoke each pair on purpose. They judge the pair by which upstream pulse fires, which state follows, and whether the forwarded tags come from the skid buffer, from the input, or from neither.

// File: rtl/dsk_pkg.sv
package dsk_pkg;
  localparam int NSRC = 3;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RUN  = 3'd1,
    ST_BLK  = 3'd2,
    ST_UNB  = 3'd3,
    ST_SQ   = 3'd4
  } st_e;
endpackage

// File: rtl/dsk_stall_track.sv
module dsk_stall_track #(
  parameter int NSRC = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic            stall_o
);
  logic [NSRC-1:0] flags_q, flags_nx;

  // clear applied after set: unblock wins
  assign flags_nx = (flags_q | set_i) & ~clr_i;
  assign stall_o  = |flags_nx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_nx;
  end

  for (genvar k = 0; k < NSRC; k++) begin : g_chk
    AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] && !clr_i[k] |=> flags_q[k]); // R2
    AST_FLAG_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[k] |=> !flags_q[k]); // R2
  end
endmodule

// File: rtl/dsk_fwd_pick.sv
module dsk_fwd_pick #(
  parameter int N     = 6,
  parameter int TAG_W = 8,
  parameter int OUT_W = 2,
  parameter int CW    = 3,
  parameter int OCW   = 2
) (
  input  logic [N-1:0][TAG_W-1:0]     tag_i,
  input  logic [N-1:0]                kill_i,
  input  logic [CW-1:0]               cnt_i,
  output logic [OUT_W-1:0][TAG_W-1:0] tag_o,
  output logic [OCW-1:0]              n_o,
  output logic [CW-1:0]               used_o
);
  localparam int OIW = (OUT_W > 1) ? $clog2(OUT_W) : 1;

  always_comb begin
    int f;
    int used;
    f     = 0;
    used  = 0;
    tag_o = '0;
    for (int i = 0; i < N; i++) begin
      if (i < int'(cnt_i) && f < OUT_W) begin
        used = i + 1;
        if (!kill_i[i]) begin
          tag_o[OIW'(f)] = tag_i[i];
          f = f + 1;
        end
      end
    end
    n_o    = OCW'(f);
    used_o = CW'(used);
  end
endmodule

// File: rtl/dsk_skid_store.sv
module dsk_skid_store #(
  parameter int DEPTH = 6,
  parameter int IN_W  = 4,
  parameter int TAG_W = 8,
  parameter int CW    = 3,
  parameter int ICW   = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        flush_i,
  input  logic [CW-1:0]               pop_i,
  input  logic                        push_i,
  input  logic [ICW-1:0]              push_off_i,
  input  logic [ICW-1:0]              in_cnt_i,
  input  logic [IN_W-1:0][TAG_W-1:0]  in_tag_i,
  input  logic [IN_W-1:0]             in_kill_i,
  output logic [DEPTH-1:0][TAG_W-1:0] tag_o,
  output logic [DEPTH-1:0]            kill_o,
  output logic [CW-1:0]               cnt_o,
  output logic                        ovf_o
);
  localparam int DIW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int JIW = (IN_W > 1) ? $clog2(IN_W) : 1;

  logic [DEPTH-1:0][TAG_W-1:0] tag_q, tag_nx;
  logic [DEPTH-1:0]            kill_q, kill_nx;
  logic [CW-1:0]               cnt_q, cnt_nx;
  logic                        ovf_q, ovf_nx;

  // shift-compacting store: pop from head, append input slice at tail
  always_comb begin
    int total;
    total = int'(cnt_q) - int'(pop_i);
    if (push_i) total = total + int'(in_cnt_i) - int'(push_off_i);
    if (flush_i) total = 0;
    ovf_nx = (total > DEPTH);
    cnt_nx = ovf_nx ? CW'(DEPTH) : CW'(total);
    tag_nx  = '0;
    kill_nx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      int src;
      int j;
      src = i + int'(pop_i);
      j   = src - int'(cnt_q) + int'(push_off_i);
      if (src < int'(cnt_q)) begin
        tag_nx[i]  = tag_q[DIW'(src)];
        kill_nx[i] = kill_q[DIW'(src)];
      end else if (push_i && j < int'(in_cnt_i)) begin
        tag_nx[i]  = in_tag_i[JIW'(j)];
        kill_nx[i] = in_kill_i[JIW'(j)];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q  <= '0;
      kill_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      tag_q  <= tag_nx;
      kill_q <= kill_nx;
      cnt_q  <= cnt_nx;
      ovf_q  <= ovf_nx;
    end
  end

  assign tag_o  = tag_q;
  assign kill_o = kill_q;
  assign cnt_o  = cnt_q;
  assign ovf_o  = ovf_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= DEPTH); // R11
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> cnt_q == '0); // R9
endmodule

// File: rtl/dec_skid_ctrl.sv
module dec_skid_ctrl
  import dsk_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int IN_W  = 4,
  parameter int OUT_W = 2,
  parameter int LAT   = 1,
  localparam int ICW  = $clog2(IN_W + 1),
  localparam int OCW  = $clog2(OUT_W + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ICW-1:0]         in_cnt_i,
  input  logic [IN_W*TAG_W-1:0]  in_tag_i,
  input  logic [IN_W-1:0]        in_kill_i,
  input  logic [2:0]             stall_set_i,
  input  logic [2:0]             stall_clr_i,
  input  logic                   squash_i,
  input  logic                   sq_busy_i,
  output logic [OCW-1:0]         out_cnt_o,
  output logic [OUT_W*TAG_W-1:0] out_tag_o,
  output logic                   up_block_o,
  output logic                   up_unblock_o,
  output logic [2:0]             state_o,
  output logic                   skid_ovf_o
);
  localparam int DEPTH = LAT * IN_W + OUT_W;
  localparam int CW    = $clog2(DEPTH + 1);

  st_e st_q, st_nx;
  logic stalled;

  logic [IN_W-1:0][TAG_W-1:0]  in_tag;
  logic [DEPTH-1:0][TAG_W-1:0] skid_tag, pad_tag, src_tag;
  logic [DEPTH-1:0]            skid_kill, pad_kill, src_kill;
  logic [CW-1:0]               skid_cnt, src_cnt, used;
  logic [OUT_W-1:0][TAG_W-1:0] pick_tag;
  logic [OCW-1:0]              pick_n;

  logic use_skid, fwd_en, push_en, flush, blk_p, unblk_p;
  logic [CW-1:0]  pop_n;
  logic [ICW-1:0] push_off;
  int rem;

  logic [OCW-1:0]              out_n_q;
  logic [OUT_W-1:0][TAG_W-1:0] out_tag_q;
  logic                        blk_q, unblk_q;

  assign in_tag = in_tag_i;

  dsk_stall_track #(.NSRC(NSRC)) u_stall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (stall_set_i),
    .clr_i  (stall_clr_i),
    .stall_o(stalled)
  );

  dsk_skid_store #(
    .DEPTH(DEPTH), .IN_W(IN_W), .TAG_W(TAG_W), .CW(CW), .ICW(ICW)
  ) u_skid (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush),
    .pop_i     (pop_n),
    .push_i    (push_en),
    .push_off_i(push_off),
    .in_cnt_i  (in_cnt_i),
    .in_tag_i  (in_tag),
    .in_kill_i (in_kill_i),
    .tag_o     (skid_tag),
    .kill_o    (skid_kill),
    .cnt_o     (skid_cnt),
    .ovf_o     (skid_ovf_o)
  );

  // input bundle widened to skid depth for a shared picker
  always_comb begin
    pad_tag  = '0;
    pad_kill = '0;
    for (int i = 0; i < IN_W; i++) begin
      pad_tag[i]  = in_tag[i];
      pad_kill[i] = in_kill_i[i];
    end
  end

  assign use_skid = !squash_i && !sq_busy_i && !stalled &&
                    (st_q == ST_UNB || (st_q == ST_BLK && skid_cnt != '0));

  assign src_tag  = use_skid ? skid_tag  : pad_tag;
  assign src_kill = use_skid ? skid_kill : pad_kill;
  assign src_cnt  = use_skid ? skid_cnt  : CW'(in_cnt_i);

  dsk_fwd_pick #(
    .N(DEPTH), .TAG_W(TAG_W), .OUT_W(OUT_W), .CW(CW), .OCW(OCW)
  ) u_pick (
    .tag_i (src_tag),
    .kill_i(src_kill),
    .cnt_i (src_cnt),
    .tag_o (pick_tag),
    .n_o   (pick_n),
    .used_o(used)
  );

  assign rem = int'(skid_cnt) - int'(used) + int'(in_cnt_i);

  always_comb begin
    st_nx    = st_q;
    fwd_en   = 1'b0;
    pop_n    = '0;
    push_en  = 1'b0;
    push_off = '0;
    flush    = 1'b0;
    blk_p    = 1'b0;
    unblk_p  = 1'b0;
    if (squash_i || sq_busy_i) begin
      flush   = 1'b1;
      unblk_p = (st_q == ST_BLK) || (st_q == ST_UNB);
      st_nx   = ST_SQ;
    end else if (stalled) begin
      push_en = 1'b1;
      if (st_q != ST_BLK) begin
        blk_p = 1'b1;
        st_nx = ST_BLK;
      end
    end else if (use_skid) begin
      fwd_en  = 1'b1;
      pop_n   = used;
      push_en = 1'b1;
      if (rem == 0) begin
        unblk_p = 1'b1;
        st_nx   = ST_RUN;
      end else begin
        st_nx   = ST_UNB;
      end
    end else begin
      fwd_en = 1'b1;
      if (int'(used) < int'(in_cnt_i)) begin
        push_en  = 1'b1;
        push_off = ICW'(used);
        blk_p    = (st_q != ST_BLK);
        st_nx    = ST_BLK;
      end else begin
        unblk_p = (st_q == ST_BLK);
        st_nx   = (st_q == ST_IDLE && in_cnt_i == '0) ? ST_IDLE : ST_RUN;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      out_n_q   <= '0;
      out_tag_q <= '0;
      blk_q     <= 1'b0;
      unblk_q   <= 1'b0;
    end else begin
      st_q      <= st_nx;
      out_n_q   <= fwd_en ? pick_n : '0;
      out_tag_q <= fwd_en ? pick_tag : '0;
      blk_q     <= blk_p;
      unblk_q   <= unblk_p;
    end
  end

  assign out_cnt_o    = out_n_q;
  assign out_tag_o    = out_tag_q;
  assign up_block_o   = blk_q;
  assign up_unblock_o = unblk_q;
  assign state_o      = st_q;

  AST_NO_DUAL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_block_o && up_unblock_o)); // R4
  AST_BLOCK_IN_BLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_block_o |-> st_q == ST_BLK); // R4
  AST_OUT_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(out_n_q) <= OUT_W); // R5
  AST_UNB_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_UNB |-> skid_cnt != '0); // R6
  AST_UNBLK_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_unblock_o && st_q != ST_SQ |-> st_q == ST_RUN && skid_cnt == '0); // R7
  AST_SQ_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_i |=> st_q == ST_SQ && skid_cnt == '0 && out_n_q == '0); // R9
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sq_busy_i |=> st_q == ST_SQ); // R10
endmodule

// File: tb/sim_dec_skid_ctrl.sv
module sim_dec_skid_ctrl;
  localparam int TW = 8;
  localparam int IW = 4;
  localparam int OW = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [2:0]    in_cnt_i = '0;
  logic [31:0]   in_tag_i = '0;
  logic [3:0]    in_kill_i = '0;
  logic [2:0]    stall_set_i = '0;
  logic [2:0]    stall_clr_i = '0;
  logic          squash_i = 1'b0;
  logic          sq_busy_i = 1'b0;
  logic [1:0]    out_cnt_o;
  logic [15:0]   out_tag_o;
  logic          up_block_o, up_unblock_o, skid_ovf_o;
  logic [2:0]    state_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  dec_skid_ctrl #(.TAG_W(TW), .IN_W(IW), .OUT_W(OW), .LAT(1)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_cnt_i(in_cnt_i), .in_tag_i(in_tag_i),
    .in_kill_i(in_kill_i), .stall_set_i(stall_set_i), .stall_clr_i(stall_clr_i),
    .squash_i(squash_i), .sq_busy_i(sq_busy_i), .out_cnt_o(out_cnt_o),
    .out_tag_o(out_tag_o), .up_block_o(up_block_o), .up_unblock_o(up_unblock_o),
    .state_o(state_o), .skid_ovf_o(skid_ovf_o)
  );

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] tg(logic [7:0] a, logic [7:0] b,
                                     logic [7:0] c, logic [7:0] d);
    return {d, c, b, a};
  endfunction

  // present one cycle of inputs, then sample after the edge
  task automatic cyc(int n, logic [31:0] tags, logic [3:0] kill,
                     logic [2:0] set, logic [2:0] clr, logic sq, logic busy);
    in_cnt_i    = 3'(n);
    in_tag_i    = tags;
    in_kill_i   = kill;
    stall_set_i = set;
    stall_clr_i = clr;
    squash_i    = sq;
    sq_busy_i   = busy;
    @(negedge clk_i);
  endtask

  task automatic outs(string r, int n, logic [7:0] t0, logic [7:0] t1);
    chk({r, " out_cnt"}, out_cnt_o, n);
    if (n > 0) chk({r, " tag0"}, out_tag_o[7:0], t0);
    if (n > 1) chk({r, " tag1"}, out_tag_o[15:8], t1);
  endtask

  task automatic t_reset;
    chk("R1 state", state_o, 0);
    chk("R1 out_cnt", out_cnt_o, 0);
    chk("R1 block", up_block_o, 0);
    chk("R1 unblock", up_unblock_o, 0);
    chk("R1 ovf", skid_ovf_o, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R12 idle hold", state_o, 0);
  endtask

  task automatic t_run;
    in_cnt_i = 3'd2; in_tag_i = tg(8'h10, 8'h11, 0, 0);
    #2 chk("R13 no early output", out_cnt_o, 0);
    cyc(2, tg(8'h10, 8'h11, 0, 0), 0, 0, 0, 0, 0);
    outs("R13", 2, 8'h10, 8'h11);
    chk("R12 to running", state_o, 1);
  endtask

  task automatic t_width;
    cyc(4, tg(8'h20, 8'h21, 8'h22, 8'h23), 0, 0, 0, 0, 0);
    outs("R5", 2, 8'h20, 8'h21);
    chk("R5 block pulse", up_block_o, 1);
    chk("R5 state blk", state_o, 2);
    cyc(0, 0, 0, 0, 0, 0, 0);
    outs("R6", 2, 8'h22, 8'h23);
    chk("R7 unblock pulse", up_unblock_o, 1);
    chk("R7 state run", state_o, 1);
  endtask

  task automatic t_stall;
    cyc(3, tg(8'h30, 8'h31, 8'h32, 0), 0, 3'b001, 0, 0, 0);
    chk("R2 stalled out", out_cnt_o, 0);
    chk("R4 block on entry", up_block_o, 1);
    cyc(1, tg(8'h33, 0, 0, 0), 0, 3'b010, 0, 0, 0);
    chk("R4 no repeat block", up_block_o, 0);
    chk("R2 stalled out2", out_cnt_o, 0);
    cyc(0, 0, 0, 0, 3'b001, 0, 0);
    chk("R2 other flag holds", state_o, 2);
    chk("R2 no output", out_cnt_o, 0);
    cyc(2, tg(8'h34, 8'h35, 0, 0), 0, 0, 3'b010, 0, 0);
    outs("R6 skid first", 2, 8'h30, 8'h31);
    chk("R6 unblocking", state_o, 3);
    chk("R6 no early unblock", up_unblock_o, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    outs("R6 drain", 2, 8'h32, 8'h33);
    cyc(0, 0, 0, 0, 0, 0, 0);
    outs("R6 appended", 2, 8'h34, 8'h35);
    chk("R7 done", up_unblock_o, 1);
    chk("R7 running", state_o, 1);
  endtask

  task automatic t_kill;
    cyc(4, tg(8'h40, 8'h41, 8'h42, 8'h43), 4'b0101, 0, 0, 0, 0);
    outs("R8", 2, 8'h41, 8'h43);
    chk("R8 no block", up_block_o, 0);
    cyc(4, tg(8'h44, 8'h45, 8'h46, 8'h47), 4'b1111, 0, 0, 0, 0);
    chk("R8 all killed", out_cnt_o, 0);
    chk("R8 still running", state_o, 1);
  endtask

  task automatic t_squash;
    cyc(4, tg(8'h50, 8'h51, 8'h52, 8'h53), 0, 3'b100, 0, 0, 0);
    cyc(0, 0, 0, 0, 3'b100, 0, 0);
    outs("R6 pre-squash", 2, 8'h50, 8'h51);
    cyc(4, tg(8'h60, 8'h61, 8'h62, 8'h63), 0, 0, 0, 1, 0);
    chk("R9 out", out_cnt_o, 0);
    chk("R9 unblock", up_unblock_o, 1);
    chk("R9 state", state_o, 4);
    cyc(2, tg(8'h70, 8'h71, 0, 0), 0, 0, 0, 0, 0);
    outs("R9 skid flushed", 2, 8'h70, 8'h71);
    chk("R3 squash exit", state_o, 1);
    cyc(0, 0, 0, 0, 0, 1, 0);
    chk("R9 no unblock from run", up_unblock_o, 0);
    chk("R9 squashing", state_o, 4);
  endtask

  task automatic t_prio;
    cyc(2, tg(8'h78, 8'h79, 0, 0), 0, 3'b001, 0, 1, 0);
    chk("R3 squash over stall", state_o, 4);
    chk("R3 no block", up_block_o, 0);
    cyc(2, tg(8'h80, 8'h81, 0, 0), 0, 0, 0, 0, 1);
    chk("R10 busy hold", state_o, 4);
    chk("R3 busy over stall", up_block_o, 0);
    chk("R10 busy out", out_cnt_o, 0);
    cyc(2, tg(8'h82, 8'h83, 0, 0), 0, 0, 0, 0, 0);
    chk("R3 stall over exit", state_o, 2);
    chk("R3 block pulse", up_block_o, 1);
    cyc(0, 0, 0, 0, 3'b001, 0, 0);
    outs("R3 recovered", 2, 8'h82, 8'h83);
    chk("R7 unblock", up_unblock_o, 1);
  endtask

  task automatic t_ovf;
    cyc(4, tg(8'h90, 8'h91, 8'h92, 8'h93), 0, 3'b001, 0, 0, 0);
    chk("R11 no ovf", skid_ovf_o, 0);
    cyc(4, tg(8'h94, 8'h95, 8'h96, 8'h97), 0, 0, 0, 0, 0);
    chk("R11 ovf pulse", skid_ovf_o, 1);
    cyc(0, 0, 0, 0, 3'b001, 0, 0);
    chk("R11 ovf single", skid_ovf_o, 0);
    outs("R11 d0", 2, 8'h90, 8'h91);
    cyc(0, 0, 0, 0, 0, 0, 0);
    outs("R11 d1", 2, 8'h92, 8'h93);
    cyc(0, 0, 0, 0, 0, 0, 0);
    outs("R11 d2", 2, 8'h94, 8'h95);
    chk("R11 excess dropped", up_unblock_o, 1);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R11 nothing left", out_cnt_o, 0);
  endtask

  task automatic t_misc;
    cyc(1, tg(8'hA5, 0, 0, 0), 0, 3'b001, 3'b001, 0, 0);
    outs("R2 clear wins", 1, 8'hA5, 0);
    chk("R2 clear wins state", state_o, 1);
    cyc(0, 0, 0, 3'b001, 0, 0, 0);
    chk("R4 block empty", up_block_o, 1);
    cyc(2, tg(8'hB0, 8'hB1, 0, 0), 0, 0, 3'b001, 0, 0);
    outs("R7 direct", 2, 8'hB0, 8'hB1);
    chk("R7 direct unblock", up_unblock_o, 1);
    chk("R7 direct run", state_o, 1);
    cyc(4, tg(8'hC0, 8'hC1, 8'hC2, 8'hC3), 0, 3'b001, 0, 0, 0);
    cyc(0, 0, 0, 0, 3'b001, 0, 1);
    chk("R10 busy unblock", up_unblock_o, 1);
    chk("R10 busy state", state_o, 4);
    cyc(1, tg(8'hD0, 0, 0, 0), 0, 0, 0, 0, 0);
    outs("R10 skid dropped", 1, 8'hD0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_run();
    t_width();
    t_stall();
    t_kill();
    t_squash();
    t_prio();
    t_ovf();
    t_misc();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule